// File: doc/BRIEF.md
# Frame Memory with Optional Second Read Port

This block is an on-chip, byte-addressable frame store with one write port and two synchronous read ports that work independently. The first read port is meant for display scanout, which fetches a byte every pixel. The second read port fetches the previous byte of a location so that the rasterizer can merge a 4-bit pixel into it (read-modify-write).

A build parameter can remove the second read port. When the port is removed, no logic on that path reads the storage array. The array then has exactly one write access and one read access, so a tool can map it to a single simple-dual-port RAM instead of two copies that share a write.

An elaboration-time guard stops the build when the second port is enabled and the memory is 256 KiB or larger. A large build, such as a 512 KiB framebuffer, must turn the port off explicitly. Arbitration between clients, pixel-format handling and off-chip storage belong to other blocks.

Top module: `frame_mem`

## Requirements
- R1: A byte presented on `wr_data` with `wr_en` high at a rising edge is stored at `wr_addr`. Later reads of that address from either port return it.
- R2: A read requested on the scanout port (`scan_rd_en` high at an edge) returns the byte on `scan_data`, with `scan_valid` high, in the cycle after the request. This is one cycle of latency.
- R3: The two read ports serve different addresses in the same cycle. Each returns its own byte.
- R4: A read of the address being written in the same cycle returns the byte held before that write. The new byte is visible from the next read onward.
- R5: In a cycle with no read request on a port, that port's valid flag is low in the following cycle, and its data output keeps the last byte read, even if the memory at that address changes.
- R6: While `rst_n` is low, both valid flags are low and both data outputs are zero.
- R7: With `AUX_READ_EN` = 0, `rmw_data` is always zero and `rmw_valid` always low, whatever the read-modify-write port requests. The scanout port and writes behave as in R1 and R2.
- R8: Elaboration stops with a fatal message when `AUX_READ_EN` = 1 and `BYTES` >= 262144. Smaller sizes, and any size with the port disabled, elaborate normally.
- R9: `AUX_READ_EN` defaults to 1, so an instance that does not set it has both read ports live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Byte to store |
| scan_rd_en | input | 1 | Scanout read request |
| scan_addr | input | ADDR_W | Scanout byte address |
| scan_data | output | 8 | Scanout read byte, one cycle after the request |
| scan_valid | output | 1 | High in the cycle after a scanout request |
| rmw_rd_en | input | 1 | Read-modify-write old-byte request |
| rmw_addr | input | ADDR_W | Read-modify-write byte address |
| rmw_data | output | 8 | Old byte for the merge; zero when the port is disabled |
| rmw_valid | output | 1 | High in the cycle after a request; low when the port is disabled |

## Verification
The bench targets read-during-write on one address from both ports at once. A design that forwards the incoming byte would return the new value there instead of the old one. It issues reads on both ports in the same cycle to different addresses, which catches swapped or shared address paths. It drops the read strobe and rewrites the last address read, to expose an output that keeps following the array or a valid flag that stays high. A second instance with the port disabled receives live read-modify-write requests, and any leak onto `rmw_data` or `rmw_valid` would show up there. The guard threshold is checked on both sides of 262144.

// File: rtl/fmem_pkg.sv
package fmem_pkg;

   // Size at which a live second read port is refused at elaboration
   localparam int unsigned AUX_BYTE_LIMIT = 262144;
   localparam int unsigned BYTE_W         = 8;

   // True when a given port setting and size may be built
   function automatic bit aux_size_ok(input bit aux_en, input longint unsigned bytes);
      return !(aux_en && (bytes >= AUX_BYTE_LIMIT));
   endfunction

endpackage

// File: rtl/fmem_array.sv
module fmem_array #(
   parameter int unsigned BYTES  = 4096,
   parameter int unsigned NUM_RD = 2,
   parameter int unsigned ADDR_W = $clog2(BYTES),
   parameter int unsigned DATA_W = fmem_pkg::BYTE_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [NUM_RD-1:0]              rd_en,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);

   logic [DATA_W-1:0] mem [BYTES];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   // One registered read per port; only instantiated ports touch mem
   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (rd_en[p]) begin
            q <= mem[rd_addr[p]];
         end
      end

      assign rd_data[p] = q;

      AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en[p] |=> $stable(rd_data[p])); // R5
   end

endmodule

// File: rtl/fmem_rd_track.sv
module fmem_rd_track (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
      end else begin
         valid <= req;
      end
   end

   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> valid); // R2

   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !valid); // R5

endmodule

// File: rtl/frame_mem.sv
module frame_mem #(
   parameter int unsigned BYTES       = 4096,
   parameter bit          AUX_READ_EN = 1'b1,
   parameter int unsigned ADDR_W      = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              scan_rd_en,
   input  logic [ADDR_W-1:0] scan_addr,
   output logic [7:0]        scan_data,
   output logic              scan_valid,
   input  logic              rmw_rd_en,
   input  logic [ADDR_W-1:0] rmw_addr,
   output logic [7:0]        rmw_data,
   output logic              rmw_valid
);

   localparam int unsigned DATA_W = fmem_pkg::BYTE_W;
   localparam int unsigned NUM_RD = AUX_READ_EN ? 2 : 1;

   // Elaboration-time parameter checks
   if (BYTES < 2) begin : g_bad_size
      $fatal(1, "frame_mem: BYTES must be at least 2");
   end
   if (ADDR_W < $clog2(BYTES)) begin : g_bad_addr
      $fatal(1, "frame_mem: ADDR_W too narrow for BYTES");
   end
   if (!fmem_pkg::aux_size_ok(AUX_READ_EN, BYTES)) begin : g_aux_guard
      $fatal(1, "frame_mem: second read port enabled on a memory of %0d bytes; limit is below %0d, clear AUX_READ_EN",
             BYTES, fmem_pkg::AUX_BYTE_LIMIT);
   end

   logic [NUM_RD-1:0]             rd_en;
   logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
   logic [NUM_RD-1:0]             rd_valid;

   fmem_array #(
      .BYTES  (BYTES),
      .NUM_RD (NUM_RD),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_trk
      fmem_rd_track u_trk (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (rd_en[p]),
         .valid (rd_valid[p])
      );
   end

   assign rd_en[0]   = scan_rd_en;
   assign rd_addr[0] = scan_addr;
   assign scan_data  = rd_data[0];
   assign scan_valid = rd_valid[0];

   if (AUX_READ_EN) begin : g_aux_on
      assign rd_en[1]   = rmw_rd_en;
      assign rd_addr[1] = rmw_addr;
      assign rmw_data   = rd_data[1];
      assign rmw_valid  = rd_valid[1];
   end else begin : g_aux_off
      // Port removed: request and address are unused, outputs are quiet
      logic unused_rmw;
      assign unused_rmw = rmw_rd_en ^ (^rmw_addr);
      assign rmw_data   = '0;
      assign rmw_valid  = 1'b0;

      AST_AUX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         rmw_rd_en |=> (!rmw_valid && (rmw_data == '0))); // R7
   end

endmodule

// File: tb/frame_mem_tb.sv
module frame_mem_tb;

   localparam int unsigned TB_BYTES = 256;
   localparam int unsigned AW       = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          scan_rd_en = 1'b0;
   logic [AW-1:0] scan_addr = '0;
   logic          rmw_rd_en = 1'b0;
   logic [AW-1:0] rmw_addr = '0;

   logic [7:0] scan_data, rmw_data, l_scan_data, l_rmw_data;
   logic       scan_valid, rmw_valid, l_scan_valid, l_rmw_valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   // Default AUX_READ_EN (R9)
   frame_mem #(.BYTES(TB_BYTES)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .scan_rd_en(scan_rd_en), .scan_addr(scan_addr), .scan_data(scan_data), .scan_valid(scan_valid),
      .rmw_rd_en(rmw_rd_en), .rmw_addr(rmw_addr), .rmw_data(rmw_data), .rmw_valid(rmw_valid)
   );

   frame_mem #(.BYTES(TB_BYTES), .AUX_READ_EN(1'b0)) u_lite (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .scan_rd_en(scan_rd_en), .scan_addr(scan_addr), .scan_data(l_scan_data), .scan_valid(l_scan_valid),
      .rmw_rd_en(rmw_rd_en), .rmw_addr(rmw_addr), .rmw_data(l_rmw_data), .rmw_valid(l_rmw_valid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = 1'b0; scan_rd_en = 1'b0; rmw_rd_en = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      idle();
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      idle();
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'(8'h30 + i * 7);
   endfunction

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R6 scan_valid in reset", 32'(scan_valid), 0);
      check("R6 rmw_valid in reset", 32'(rmw_valid), 0);
      check("R6 scan_data in reset", 32'(scan_data), 0);
      check("R6 rmw_data in reset", 32'(rmw_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_write_read();
      for (int i = 0; i < 8; i++) wr(8'(i * 5), pat(i));
      for (int i = 0; i < 8; i++) begin
         scan_rd_en = 1'b1; scan_addr = 8'(i * 5);
         @(negedge clk);
         idle();
         check("R2 scan_valid after request", 32'(scan_valid), 1);
         check("R1 R2 scan_data", 32'(scan_data), 32'(pat(i)));
      end
   endtask

   task automatic t_dual();
      // R3/R9: both ports in the same cycle, different addresses
      for (int i = 0; i < 4; i++) begin
         scan_rd_en = 1'b1; scan_addr = 8'(i * 5);
         rmw_rd_en  = 1'b1; rmw_addr  = 8'((7 - i) * 5);
         @(negedge clk);
         idle();
         check("R3 scan_data dual", 32'(scan_data), 32'(pat(i)));
         check("R3 R9 rmw_data dual", 32'(rmw_data), 32'(pat(7 - i)));
         check("R3 R9 rmw_valid dual", 32'(rmw_valid), 1);
      end
   endtask

   task automatic t_rdw();
      wr(8'd99, 8'hA5);
      wr_en = 1'b1; wr_addr = 8'd99; wr_data = 8'h5A;
      scan_rd_en = 1'b1; scan_addr = 8'd99;
      rmw_rd_en  = 1'b1; rmw_addr  = 8'd99;
      @(negedge clk);
      idle();
      check("R4 scan old byte on same-cycle write", 32'(scan_data), 32'hA5);
      check("R4 rmw old byte on same-cycle write", 32'(rmw_data), 32'hA5);
      scan_rd_en = 1'b1; rmw_rd_en = 1'b1;
      @(negedge clk);
      idle();
      check("R4 scan new byte next read", 32'(scan_data), 32'h5A);
      check("R4 rmw new byte next read", 32'(rmw_data), 32'h5A);
   endtask

   task automatic t_hold();
      scan_addr = 8'd3; rmw_addr = 8'd4;
      wr(8'd3, 8'h11);
      wr(8'd4, 8'h22);
      scan_rd_en = 1'b1; rmw_rd_en = 1'b1;
      @(negedge clk);
      idle();
      // no request now, and the read addresses get rewritten
      wr_en = 1'b1; wr_addr = 8'd3; wr_data = 8'hEE;
      @(negedge clk);
      wr_addr = 8'd4; wr_data = 8'hDD;
      check("R5 scan_valid low when idle", 32'(scan_valid), 0);
      check("R5 rmw_valid low when idle", 32'(rmw_valid), 0);
      @(negedge clk);
      idle();
      check("R5 scan_data held", 32'(scan_data), 32'h11);
      check("R5 rmw_data held", 32'(rmw_data), 32'h22);
   endtask

   task automatic t_lite();
      wr(8'd200, 8'h6C);
      wr(8'd201, 8'h93);
      for (int i = 0; i < 2; i++) begin
         scan_rd_en = 1'b1; scan_addr = 8'(200 + i);
         rmw_rd_en  = 1'b1; rmw_addr  = 8'(201 - i);
         @(negedge clk);
         idle();
         check("R7 lite rmw_valid stays low", 32'(l_rmw_valid), 0);
         check("R7 lite rmw_data zero", 32'(l_rmw_data), 0);
         check("R7 lite scan_valid", 32'(l_scan_valid), 1);
         check("R7 lite scan_data", 32'(l_scan_data), (i == 0) ? 32'h6C : 32'h93);
      end
   endtask

   task automatic t_guard();
      check("R8 enabled just below limit", 32'(fmem_pkg::aux_size_ok(1'b1, 262143)), 1);
      check("R8 enabled at limit refused", 32'(fmem_pkg::aux_size_ok(1'b1, 262144)), 0);
      check("R8 disabled at 512 KiB allowed", 32'(fmem_pkg::aux_size_ok(1'b0, 524288)), 1);
   endtask

   initial begin
      t_reset();
      t_write_read();
      t_dual();
      t_rdw();
      t_hold();
      t_lite();
      t_guard();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule